// File: doc/BRIEF.md
# Serial Command Writer for a Character Display Controller

This block is the host-facing front end of a dot-matrix display controller. A host drives a write-only three-wire serial link: an active-low select, a serial clock and a data line. The block brings those wires into the system clock domain and assembles bytes. The first byte of every selection is a command. A command either loads one of the control registers or opens a write burst into one of three memories: the character-code RAM (one code per digit position), the user glyph RAM (eight 5x8 patterns) or the symbol RAM (two symbol bits per digit).

Data bytes that follow a burst command are presented on a single-cycle write port together with an address that advances by itself. The glyph RAM takes five column bytes per glyph. The control registers (brightness duty, digit count, port pins and display mode), the standby wake-up on a select falling edge and the reset defaults are also held here. The display scan that reads the memories lives elsewhere.

Top module: `vfd_cmd_writer`

## Requirements
- R1: Bytes are received only while `csN` is low. Each rising edge of `sclk` samples one bit of `sdi`, least significant bit first, and eight bits make a byte. The first byte after `csN` falls is a command.
- R2: Command bits 7:5 select the function: 000 character write, 001 glyph write, 010 symbol write, 011 port set, 100 duty set, 101 digit-count set, 110 display mode, 111 test. A data byte drives at most one of `wrChar`, `wrGlyph` and `wrSym` for one cycle.
- R3: A character write command carries its start address in bits 4:0. Each following byte is presented with `wrChar`, with `wrData` equal to the byte and `wrAddr` equal to the current address. The address then rises by one, and after address 23 it returns to the start address.
- R4: A character or symbol write command whose start address is 24 to 31 produces no write for the rest of that selection.
- R5: A glyph write command carries the glyph index in bits 2:0. Each following byte is presented with `wrGlyph`, with `wrAddr` set to the index and `wrCol` counting 0 to 4. After column 4 the index rises by one, and after index 7 it returns to the start index.
- R6: A symbol write command addresses as in R3 and R4. Each following byte is presented with `wrSym`, and `wrData` holds bits 1:0 of the byte with the upper six bits zero.
- R7: The port command loads bits 1:0 into the port register, the duty command loads bits 2:0 into `dutyCode`, the digit-count command loads bits 3:0 into `digitCode`, and the mode command loads bits 3:0 into `modeBits`, ordered D (bit 3), S (bit 2), H (bit 1), L (bit 0). Bytes that follow a register command in the same selection are ignored.
- R8: After reset `portPins` is 11, `dutyCode`, `digitCode` and `modeBits` are 0, `testEngaged` is 0 and no write strobe is active.
- R9: If `csN` rises in the middle of a byte, the partial bits are discarded and the burst ends. The first byte of the next selection is decoded as a command.
- R10: While S is 1, `portPins` reads 11. The port register keeps its value and shows again once S clears.
- R11: A falling edge of `csN` while S is 1 clears both S and D and leaves H and L unchanged.
- R12: A test command sets `testEngaged` only if the byte is exactly E0h and `testMode` is high. Any other byte with opcode 111 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data, LSB first |
| testMode | input | 1 | Enables acceptance of the test command |
| wrChar | output | 1 | Character RAM write strobe |
| wrGlyph | output | 1 | Glyph RAM write strobe |
| wrSym | output | 1 | Symbol RAM write strobe |
| wrAddr | output | 5 | Write address (digit position or glyph index) |
| wrCol | output | 3 | Glyph column 0 to 4 (zero for other memories) |
| wrData | output | 8 | Write data |
| dutyCode | output | 3 | Duty selection, 0 means 8/16 |
| digitCode | output | 4 | Digit-count selection, 0 means 24 digits |
| modeBits | output | 4 | Display mode {D,S,H,L} |
| portPins | output | 2 | General port pin levels |
| testEngaged | output | 1 | Test command has been accepted |

## Verification
The write path is tried with directed bursts that start mid-range, start near the top so that the address wraps back to the start rather than to zero, and start in the unused range 24 to 31. A burst in that range must leave every memory untouched. Glyph bursts of ten bytes starting at index 6 and index 7 separate wrap-to-start from wrap-to-zero and check that the column counter rolls into the next glyph. Random bursts over all three memories with random lengths and start addresses are checked against a bench memory model, which catches address-advance or masking slips that the directed cases miss. A select raised mid-byte, trailing bytes after a register command, standby with a changed port register, wake-up and the test gating each target one control path.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;

  localparam int BYTE_W      = 8;
  localparam int OP_W        = 3;
  localparam int CHAR_DEPTH  = 24;
  localparam int ADDR_W      = 5;
  localparam int GLYPH_DEPTH = 8;
  localparam int GLYPH_AW    = 3;
  localparam int GLYPH_COLS  = 5;
  localparam int COL_W       = 3;
  localparam int SYM_W       = 2;
  localparam int PORT_W      = 2;
  localparam int DUTY_W      = 3;
  localparam int DIGIT_W     = 4;
  localparam int MODE_W      = 4;
  localparam int MODE_S_BIT  = 2;
  localparam int MODE_D_BIT  = 3;
  localparam logic [BYTE_W-1:0] TEST_CODE = 8'hE0;

  typedef enum logic [OP_W-1:0] {
    OP_CHAR   = 3'd0,
    OP_GLYPH  = 3'd1,
    OP_SYM    = 3'd2,
    OP_PORT   = 3'd3,
    OP_DUTY   = 3'd4,
    OP_DIGITS = 3'd5,
    OP_MODE   = 3'd6,
    OP_TEST   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    MEM_CHAR  = 2'd0,
    MEM_GLYPH = 2'd1,
    MEM_SYM   = 2'd2
  } memSel_e;

  typedef struct packed {
    logic    openBurst;
    logic    dataByte;
    memSel_e target;
    logic    setPort;
    logic    setDuty;
    logic    setDigits;
    logic    setMode;
    logic    setTest;
    logic    wake;
  } ctlStrobe_t;

endpackage

// File: rtl/vfd_serial_rx.sv
module vfd_serial_rx #(
  parameter int BYTE_W = vfd_cmd_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              byteValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              csIdle,
  output logic              csFall
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [2:0] csSync;
  logic [2:0] ckSync;
  logic [2:0] dSync;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0] shiftReg;
  logic ckRise;
  logic dataBit;

  // two-flop synchronisers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      ckSync <= '0;
      dSync  <= '0;
    end else begin
      csSync <= {csSync[1:0], csN};
      ckSync <= {ckSync[1:0], sclk};
      dSync  <= {dSync[1:0], sdi};
    end
  end

  assign csIdle  = csSync[1];
  assign csFall  = csSync[2] & ~csSync[1];
  assign ckRise  = ckSync[1] & ~ckSync[2];
  assign dataBit = dSync[2] | (dSync[1] & dSync[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      rxByte    <= '0;
      byteValid <= 1'b0;
    end else if (csIdle) begin
      bitCnt    <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (ckRise) begin
        if (bitCnt == LAST_BIT) begin
          rxByte    <= {dataBit, shiftReg};
          byteValid <= 1'b1;
          bitCnt    <= '0;
        end else begin
          shiftReg <= {dataBit, shiftReg[BYTE_W-2:1]};
          bitCnt   <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/vfd_cmd_ctrl.sv
module vfd_cmd_ctrl
  import vfd_cmd_pkg::*;
#(
  parameter int CHAR_DEPTH = vfd_cmd_pkg::CHAR_DEPTH,
  parameter int ADDR_W     = vfd_cmd_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              csIdle,
  input  logic              csFall,
  input  logic              testMode,
  output ctlStrobe_t        strobe
);

  typedef enum logic [1:0] {ST_CMD, ST_BURST, ST_DRAIN} state_e;

  state_e  state, nextState;
  memSel_e burstSel;
  opcode_e opcode;
  logic    startOk;

  assign opcode  = opcode_e'(rxByte[BYTE_W-1 -: OP_W]);
  assign startOk = rxByte[ADDR_W-1:0] < ADDR_W'(CHAR_DEPTH);

  always_comb begin
    strobe        = '0;
    strobe.target = burstSel;
    strobe.wake   = csFall;
    nextState     = state;
    if (byteValid) begin
      unique case (state)
        ST_CMD: begin
          nextState = ST_DRAIN;
          unique case (opcode)
            OP_CHAR: begin
              strobe.target = MEM_CHAR;
              if (startOk) begin
                strobe.openBurst = 1'b1;
                nextState        = ST_BURST;
              end
            end
            OP_SYM: begin
              strobe.target = MEM_SYM;
              if (startOk) begin
                strobe.openBurst = 1'b1;
                nextState        = ST_BURST;
              end
            end
            OP_GLYPH: begin
              strobe.target    = MEM_GLYPH;
              strobe.openBurst = 1'b1;
              nextState        = ST_BURST;
            end
            OP_PORT:   strobe.setPort   = 1'b1;
            OP_DUTY:   strobe.setDuty   = 1'b1;
            OP_DIGITS: strobe.setDigits = 1'b1;
            OP_MODE:   strobe.setMode   = 1'b1;
            OP_TEST:   strobe.setTest   = testMode && (rxByte == TEST_CODE);
            default:   ;
          endcase
        end
        ST_BURST: strobe.dataByte = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      burstSel <= MEM_CHAR;
    end else if (csIdle) begin
      state <= ST_CMD;
    end else begin
      state <= nextState;
      if (strobe.openBurst) burstSel <= strobe.target;
    end
  end

endmodule

// File: rtl/vfd_cmd_dp.sv
module vfd_cmd_dp
  import vfd_cmd_pkg::*;
#(
  parameter int CHAR_DEPTH  = vfd_cmd_pkg::CHAR_DEPTH,
  parameter int ADDR_W      = vfd_cmd_pkg::ADDR_W,
  parameter int GLYPH_DEPTH = vfd_cmd_pkg::GLYPH_DEPTH,
  parameter int GLYPH_AW    = vfd_cmd_pkg::GLYPH_AW,
  parameter int GLYPH_COLS  = vfd_cmd_pkg::GLYPH_COLS,
  parameter int COL_W       = vfd_cmd_pkg::COL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  rxByte,
  output logic               wrChar,
  output logic               wrGlyph,
  output logic               wrSym,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [COL_W-1:0]   wrCol,
  output logic [BYTE_W-1:0]  wrData,
  output logic [DUTY_W-1:0]  dutyCode,
  output logic [DIGIT_W-1:0] digitCode,
  output logic [MODE_W-1:0]  modeBits,
  output logic [PORT_W-1:0]  portPins,
  output logic               testEngaged
);

  localparam int N_MEM = 3;
  localparam logic [ADDR_W-1:0] CHAR_LAST  = ADDR_W'(CHAR_DEPTH - 1);
  localparam logic [ADDR_W-1:0] GLYPH_LAST = ADDR_W'(GLYPH_DEPTH - 1);
  localparam logic [COL_W-1:0]  COL_LAST   = COL_W'(GLYPH_COLS - 1);

  logic [ADDR_W-1:0] curAddr, startAddr, lastAddr, openAddr;
  logic [COL_W-1:0]  colIdx;
  logic [PORT_W-1:0] portReg;
  logic [N_MEM-1:0]  wrVec;
  logic              isGlyph, isSym;

  assign isGlyph  = (strobe.target == MEM_GLYPH);
  assign isSym    = (strobe.target == MEM_SYM);
  assign lastAddr = isGlyph ? GLYPH_LAST : CHAR_LAST;
  assign openAddr = isGlyph ? ADDR_W'(rxByte[GLYPH_AW-1:0]) : rxByte[ADDR_W-1:0];

  // one strobe flop per memory
  for (genvar m = 0; m < N_MEM; m++) begin : gWrStrobe
    logic wrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wrQ <= 1'b0;
      else       wrQ <= strobe.dataByte && (strobe.target == memSel_e'(m));
    end
    assign wrVec[m] = wrQ;
  end

  assign wrChar  = wrVec[MEM_CHAR];
  assign wrGlyph = wrVec[MEM_GLYPH];
  assign wrSym   = wrVec[MEM_SYM];

  // address sequencing and write payload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      startAddr <= '0;
      colIdx    <= '0;
      wrAddr    <= '0;
      wrCol     <= '0;
      wrData    <= '0;
    end else if (strobe.openBurst) begin
      curAddr   <= openAddr;
      startAddr <= openAddr;
      colIdx    <= '0;
    end else if (strobe.dataByte) begin
      wrAddr <= curAddr;
      wrCol  <= isGlyph ? colIdx : '0;
      wrData <= isSym ? {{(BYTE_W-SYM_W){1'b0}}, rxByte[SYM_W-1:0]} : rxByte;
      if (isGlyph && (colIdx != COL_LAST)) begin
        colIdx <= colIdx + COL_W'(1);
      end else begin
        colIdx  <= '0;
        curAddr <= (curAddr == lastAddr) ? startAddr : curAddr + ADDR_W'(1);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portReg     <= '1;
      dutyCode    <= '0;
      digitCode   <= '0;
      modeBits    <= '0;
      testEngaged <= 1'b0;
    end else begin
      if (strobe.setPort)   portReg   <= rxByte[PORT_W-1:0];
      if (strobe.setDuty)   dutyCode  <= rxByte[DUTY_W-1:0];
      if (strobe.setDigits) digitCode <= rxByte[DIGIT_W-1:0];
      if (strobe.setTest)   testEngaged <= 1'b1;
      if (strobe.setMode) begin
        modeBits <= rxByte[MODE_W-1:0];
      end else if (strobe.wake && modeBits[MODE_S_BIT]) begin
        modeBits[MODE_S_BIT] <= 1'b0;
        modeBits[MODE_D_BIT] <= 1'b0;
      end
    end
  end

  assign portPins = modeBits[MODE_S_BIT] ? '1 : portReg;

endmodule

// File: rtl/vfd_cmd_writer.sv
module vfd_cmd_writer
  import vfd_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               testMode,
  output logic               wrChar,
  output logic               wrGlyph,
  output logic               wrSym,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [COL_W-1:0]   wrCol,
  output logic [BYTE_W-1:0]  wrData,
  output logic [DUTY_W-1:0]  dutyCode,
  output logic [DIGIT_W-1:0] digitCode,
  output logic [MODE_W-1:0]  modeBits,
  output logic [PORT_W-1:0]  portPins,
  output logic               testEngaged
);

  logic              byteValid;
  logic [BYTE_W-1:0] rxByte;
  logic              csIdle, csFall;
  ctlStrobe_t        strobe;

  vfd_serial_rx #(.BYTE_W(BYTE_W)) rx_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .byteValid(byteValid), .rxByte(rxByte), .csIdle(csIdle), .csFall(csFall)
  );

  vfd_cmd_ctrl #(.CHAR_DEPTH(CHAR_DEPTH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .rxByte(rxByte),
    .csIdle(csIdle), .csFall(csFall), .testMode(testMode), .strobe(strobe)
  );

  vfd_cmd_dp #(
    .CHAR_DEPTH(CHAR_DEPTH), .ADDR_W(ADDR_W), .GLYPH_DEPTH(GLYPH_DEPTH),
    .GLYPH_AW(GLYPH_AW), .GLYPH_COLS(GLYPH_COLS), .COL_W(COL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .wrChar(wrChar), .wrGlyph(wrGlyph), .wrSym(wrSym), .wrAddr(wrAddr),
    .wrCol(wrCol), .wrData(wrData), .dutyCode(dutyCode), .digitCode(digitCode),
    .modeBits(modeBits), .portPins(portPins), .testEngaged(testEngaged)
  );

endmodule

// File: rtl/vfd_cmd_writer_chk.sv
module vfd_cmd_writer_chk
  import vfd_cmd_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               testMode,
  input logic               wrChar,
  input logic               wrGlyph,
  input logic               wrSym,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [COL_W-1:0]   wrCol,
  input logic [BYTE_W-1:0]  wrData,
  input logic [MODE_W-1:0]  modeBits,
  input logic               testEngaged
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrChar, wrGlyph, wrSym})); // R2

  AST_CHAR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrChar |-> (wrAddr < ADDR_W'(CHAR_DEPTH))); // R3

  AST_GLYPH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrGlyph |-> ((wrAddr < ADDR_W'(GLYPH_DEPTH)) && (wrCol < COL_W'(GLYPH_COLS)))); // R5

  AST_SYM_MASK: assert property (@(posedge clk) disable iff (!rstN)
    wrSym |-> ((wrData[BYTE_W-1:SYM_W] == '0) && (wrAddr < ADDR_W'(CHAR_DEPTH)))); // R6

  AST_WAKE_CLEARS_D: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeBits[MODE_S_BIT]) |-> !modeBits[MODE_D_BIT]); // R11

  AST_TEST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testEngaged) |-> $past(testMode)); // R12

endmodule

bind vfd_cmd_writer vfd_cmd_writer_chk chk_i (
  .clk(clk), .rstN(rstN), .testMode(testMode), .wrChar(wrChar),
  .wrGlyph(wrGlyph), .wrSym(wrSym), .wrAddr(wrAddr), .wrCol(wrCol),
  .wrData(wrData), .modeBits(modeBits), .testEngaged(testEngaged)
);

// File: tb/vfd_cmd_writer_tb.sv
module vfd_cmd_writer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, testMode = 1'b0;
  logic wrChar, wrGlyph, wrSym, testEngaged;
  logic [4:0] wrAddr;
  logic [2:0] wrCol;
  logic [7:0] wrData;
  logic [2:0] dutyCode;
  logic [3:0] digitCode, modeBits;
  logic [1:0] portPins;

  int checks = 0, fails = 0, obsWr = 0, expWr = 0;
  bit done = 1'b0;
  logic [7:0] obsChar [24], expChar [24], obsSym [24], expSym [24];
  logic [7:0] obsGlyph [8][5], expGlyph [8][5];

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_cmd_writer dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .testMode(testMode),
    .wrChar(wrChar), .wrGlyph(wrGlyph), .wrSym(wrSym), .wrAddr(wrAddr), .wrCol(wrCol),
    .wrData(wrData), .dutyCode(dutyCode), .digitCode(digitCode), .modeBits(modeBits),
    .portPins(portPins), .testEngaged(testEngaged)
  );

  // capture writes at the ports
  always @(negedge clk) begin
    if (rstN) begin
      if (wrChar)  begin obsChar[wrAddr] = wrData; obsWr++; end
      if (wrSym)   begin obsSym[wrAddr] = wrData; obsWr++; end
      if (wrGlyph) begin obsGlyph[wrAddr[2:0]][wrCol] = wrData; obsWr++; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 0; i < nBits; i++) begin
      @(posedge clk); sdi = b[i]; sclk = 1'b0;
      repeat (HALF_SCK) @(posedge clk);
      sclk = 1'b1;
      repeat (HALF_SCK) @(posedge clk);
    end
  endtask

  task automatic csLow();
    @(posedge clk); csN = 1'b0;
    repeat (HALF_SCK) @(posedge clk);
  endtask

  task automatic csHigh();
    repeat (HALF_SCK) @(posedge clk);
    csN = 1'b1; sclk = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic oneCmd(input logic [7:0] b);
    csLow(); sendBits(b, 8); csHigh();
  endtask

  // op: 0 character, 1 glyph, 2 symbol; model follows R3..R6
  task automatic ramBurst(input int op, input int start, input int n);
    int addr, col;
    logic [7:0] b;
    csLow();
    sendBits({op[2:0], start[4:0]}, 8);
    addr = (op == 1) ? (start & 7) : start;
    col = 0;
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      sendBits(b, 8);
      if (op == 1) begin
        expGlyph[addr][col] = b; expWr++;
        col++;
        if (col == 5) begin col = 0; addr = (addr == 7) ? (start & 7) : addr + 1; end
      end else if (start < 24) begin
        if (op == 0) expChar[addr] = b; else expSym[addr] = b & 8'h03;
        expWr++;
        addr = (addr == 23) ? start : addr + 1;
      end
    end
    csHigh();
  endtask

  task automatic compareAll(input string req);
    for (int a = 0; a < 24; a++) begin
      chk(obsChar[a] === expChar[a], req, $sformatf("char[%0d]", a), obsChar[a], expChar[a]);
      chk(obsSym[a] === expSym[a], req, $sformatf("sym[%0d]", a), obsSym[a], expSym[a]);
    end
    for (int g = 0; g < 8; g++)
      for (int c = 0; c < 5; c++)
        chk(obsGlyph[g][c] === expGlyph[g][c], req, $sformatf("glyph[%0d][%0d]", g, c),
            obsGlyph[g][c], expGlyph[g][c]);
    chk(obsWr == expWr, req, "write count", obsWr, expWr);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 24; a++) begin
      obsChar[a] = '0; expChar[a] = '0; obsSym[a] = '0; expSym[a] = '0;
    end
    for (int g = 0; g < 8; g++)
      for (int c = 0; c < 5; c++) begin obsGlyph[g][c] = '0; expGlyph[g][c] = '0; end

    repeat (4) @(posedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(portPins == 2'b11, "R8", "portPins", portPins, 3);
    chk(dutyCode == 0, "R8", "dutyCode", dutyCode, 0);
    chk(digitCode == 0, "R8", "digitCode", digitCode, 0);
    chk(modeBits == 0, "R8", "modeBits", modeBits, 0);
    chk(testEngaged == 0, "R8", "testEngaged", testEngaged, 0);
    chk({wrChar, wrGlyph, wrSym} == 0, "R8", "write strobes", {wrChar, wrGlyph, wrSym}, 0);

    // R1 R3 plain character burst
    ramBurst(0, 3, 4);
    compareAll("R1/R3 char burst");
    // R3 wrap to start, not to zero
    ramBurst(0, 22, 5);
    compareAll("R3 char wrap");
    // R4 unused start addresses
    ramBurst(0, 24, 3);
    ramBurst(2, 31, 2);
    compareAll("R4 invalid start");
    // R6 symbol masking
    ramBurst(2, 5, 3);
    ramBurst(2, 23, 3);
    compareAll("R6 symbol");
    // R5 glyph columns and index roll / wrap
    ramBurst(1, 6, 10);
    compareAll("R5 glyph roll");
    ramBurst(1, 7, 10);
    compareAll("R5 glyph wrap");

    // R2 R7 register commands with masking
    oneCmd(8'h7D);
    chk(portPins == 2'b01, "R7", "port", portPins, 1);
    oneCmd(8'h9E);
    chk(dutyCode == 3'd6, "R7", "duty", dutyCode, 6);
    oneCmd(8'hBB);
    chk(digitCode == 4'hB, "R2", "digits", digitCode, 11);
    // R7 trailing byte after register command ignored (0x63 would set port 11)
    csLow(); sendBits(8'h85, 8); sendBits(8'h63, 8); sendBits(8'h00, 8); csHigh();
    chk(dutyCode == 3'd5, "R7", "duty with trailer", dutyCode, 5);
    chk(portPins == 2'b01, "R7", "port after trailer", portPins, 1);
    compareAll("R7 trailer no write");

    // R9 mid-byte abort
    csLow(); sendBits(8'h00, 8); sendBits(8'hAA, 8); sendBits(8'hFF, 4); csHigh();
    expChar[0] = 8'hAA; expWr++;
    oneCmd(8'h87);
    chk(dutyCode == 3'd7, "R9", "duty after abort", dutyCode, 7);
    compareAll("R9 abort");

    // R10 standby forces port high, R11 wake
    oneCmd(8'hCE);
    chk(modeBits == 4'hE, "R7", "mode", modeBits, 14);
    chk(portPins == 2'b11, "R10", "port in standby", portPins, 3);
    csLow(); csHigh();
    chk(modeBits == 4'h2, "R11", "mode after wake", modeBits, 2);
    chk(portPins == 2'b01, "R10", "port after wake", portPins, 1);
    oneCmd(8'hC9);
    csLow(); csHigh();
    chk(modeBits == 4'h9, "R11", "no wake without standby", modeBits, 9);

    // R12 test gating
    testMode = 1'b0;
    oneCmd(8'hE0);
    chk(testEngaged == 0, "R12", "test low", testEngaged, 0);
    testMode = 1'b1;
    oneCmd(8'hE1);
    chk(testEngaged == 0, "R12", "wrong code", testEngaged, 0);
    oneCmd(8'hE0);
    chk(testEngaged == 1, "R12", "accepted", testEngaged, 1);
    testMode = 1'b0;

    // random bursts over all memories
    for (int r = 0; r < 20; r++)
      ramBurst(int'($urandom_range(2, 0)), int'($urandom_range(31, 0)),
               int'($urandom_range(12, 1)));
    compareAll("R2/R3/R5/R6 random");

    done = 1'b1;
    finishRun();
  end

endmodule